// File: doc/BRIEF.md
# Shared data-ready serial ADC reader

This block reads conversion results from a 24-bit serial converter whose single output line does two jobs. Between conversions the line acts as an active-low "result ready" flag. During a read it carries the data bits. The block passes the line through a two-flop synchronizer and waits in an armed state for the line to go from high to low. When it sees that falling edge, it disarms its trigger and produces a burst of serial clock pulses from a parameterised divider. It captures one bit on each falling serial clock edge, most significant bit first. When the transfer ends, it presents the word with a one-cycle valid strobe.

A mode input selects one of two transfer lengths. In the short mode the transfer has 24 clocks, and the converter is left to pull the line high again before its next ready edge. In the extended mode a 25th clock follows the data clocks and forces the line high straight away. The trigger is re-armed only after the transfer completes. Once re-armed, the block must see the line high before a falling edge can start another read. Because of this, a data bit left low at the end of a transfer cannot be taken for a new ready flag.

The half-period of the serial clock must be at least 3 system clocks. This leaves the synchronizer enough time to settle each bit before it is captured.

Top module: `adc_rdy_reader`

## Requirements
- R1: While reset is high and on the first cycle after it, `sclk_o` is 0, `word_vld_o` is 0 and `word_o` is all zeros.
- R2: A read starts only on a falling edge of the synchronized line while the block is armed. The first rising edge of `sclk_o` comes HALF_CYC clocks after the start cycle.
- R3: A read gives exactly 24 `sclk_o` pulses when `mode_ext_i` is 0 and exactly 25 pulses when it is 1. The mode is the value sampled in the start cycle.
- R4: Bits are captured on the falling edges of `sclk_o` at the first 24 pulses. The first bit captured lands in `word_o[23]` and the last in `word_o[0]`.
- R5: `sclk_o` is low whenever no read is in progress. Each high phase and each low phase of a pulse lasts HALF_CYC clocks.
- R6: `word_vld_o` is high for exactly one cycle per read, in the same cycle that `word_o` takes the new result. `word_o` holds its value until the next strobe.
- R7: Transitions on the line during a read never start a second read. Each read produces exactly one strobe.
- R8: After re-arming, or after reset, a line that is already low does not start a read. The line must first be seen high and then fall.
- R9: Changing `mode_ext_i` during a read has no effect on the length of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdo_rdy_i | input | 1 | Shared ready/data line from the converter (asynchronous) |
| mode_ext_i | input | 1 | 1 selects 25-clock transfers, 0 selects 24-clock transfers |
| sclk_o | output | 1 | Serial clock to the converter, idle low |
| word_o | output | DATA_W | Last captured result, MSB first on the wire |
| word_vld_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest case to reach from the ports is a stale low level on the line just after re-arming. Producing it needs a short-mode transfer whose last bit is 0, with the converter model then holding the line low for many cycles before it raises it. The bench also holds the line low through and after reset, and it flips the mode input in the middle of a transfer. A behavioural model of the converter drives each new bit on every rising serial clock. A per-cycle reference model predicts the serial clock, the strobe and the word.

// File: rtl/adc_rdy_pkg.sv
package adc_rdy_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_SHIFT = 2'd1,
    RD_EXTRA = 2'd2,
    RD_DONE  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/rdr_line_arm.sv
// Synchronizes the shared line and raises a start request on a falling
// edge while armed. The edge only counts if the line was seen high since arming.
module rdr_line_arm (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic arm_i,
  output logic line_s_o,
  output logic start_o
);
  logic s1_q, s2_q, seen_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !arm_i) seen_hi_q <= 1'b0;
    else if (s2_q)     seen_hi_q <= 1'b1;
  end

  assign line_s_o = s2_q;
  assign start_o  = arm_i && seen_hi_q && !s2_q;

  // R8: a start always follows a cycle in which the line was high
  a_r8_start_after_high: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(line_s_o));
endmodule

// File: rtl/rdr_half_div.sv
// Divider that emits one tick per serial clock half-period while running.
module rdr_half_div #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R5: never counts while stopped
  a_r5_div_idle: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/adc_rdy_reader.sv
module adc_rdy_reader
  import adc_rdy_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdo_rdy_i,
  input  logic              mode_ext_i,
  output logic              sclk_o,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int BW = $clog2(DATA_W + 2);

  rd_state_e         state_q;
  logic              line_s, start, tick, run;
  logic              sclk_q, ext_q, vld_q;
  logic [BW-1:0]     bits_q;
  logic [DATA_W-1:0] sh_q, word_q;

  assign run = (state_q == RD_SHIFT) || (state_q == RD_EXTRA);

  rdr_line_arm u_arm (
    .clk(clk), .rst(rst), .line_i(sdo_rdy_i),
    .arm_i(state_q == RD_IDLE), .line_s_o(line_s), .start_o(start)
  );

  rdr_half_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rst(rst), .run_i(run), .tick_o(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RD_IDLE;
      sclk_q  <= 1'b0;
      ext_q   <= 1'b0;
      bits_q  <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (state_q)
        RD_IDLE: if (start) begin
          state_q <= RD_SHIFT;
          sclk_q  <= 1'b0;
          bits_q  <= '0;
          ext_q   <= mode_ext_i;
        end
        RD_SHIFT: if (tick) begin
          sclk_q <= !sclk_q;
          if (sclk_q) begin
            sh_q   <= {sh_q[DATA_W-2:0], line_s};
            bits_q <= bits_q + 1'b1;
            if (bits_q == BW'(DATA_W - 1))
              state_q <= ext_q ? RD_EXTRA : RD_DONE;
          end
        end
        RD_EXTRA: if (tick) begin
          sclk_q <= !sclk_q;
          if (sclk_q) state_q <= RD_DONE;
        end
        RD_DONE: begin
          word_q  <= sh_q;
          vld_q   <= 1'b1;
          state_q <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign sclk_o     = sclk_q;
  assign word_o     = word_q;
  assign word_vld_o = vld_q;

  // checker: falling serial clock edges in the current read
  logic [BW-1:0] npulse_q;
  always_ff @(posedge clk) begin
    if (rst || state_q == RD_IDLE) npulse_q <= '0;
    else if (tick && sclk_q)       npulse_q <= npulse_q + 1'b1;
  end

  a_r3_pulse_count: assert property (@(posedge clk) disable iff (rst)
    (state_q == RD_DONE) |-> (npulse_q == (ext_q ? BW'(DATA_W + 1) : BW'(DATA_W))));
  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    (state_q == RD_IDLE) |-> !sclk_o);
  a_r6_vld_single: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);
  a_r6_word_hold: assert property (@(posedge clk) disable iff (rst)
    !word_vld_o |-> $stable(word_o));
  a_r7_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    (state_q != RD_IDLE) |-> !start);
  a_r9_mode_locked: assert property (@(posedge clk) disable iff (rst)
    (state_q != RD_IDLE && $past(state_q) != RD_IDLE) |-> $stable(ext_q));
endmodule

// File: tb/tb_adc_rdy_reader.sv
`timescale 1ns/1ps
module tb_adc_rdy_reader;
  localparam int DW   = 24;
  localparam int HALF = 4;

  logic clk = 1'b0, rst = 1'b1, line = 1'b0, mode_ext = 1'b0;
  logic sclk_o, word_vld_o;
  logic [DW-1:0] word_o;

  always #4 clk = ~clk;

  adc_rdy_reader #(.DATA_W(DW), .HALF_CYC(HALF)) dut (
    .clk(clk), .rst(rst), .sdo_rdy_i(line), .mode_ext_i(mode_ext),
    .sclk_o(sclk_o), .word_o(word_o), .word_vld_o(word_vld_o)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model: new bit on each rising serial clock, 25th forces high
  logic [DW-1:0] adc_word = '0;
  int adc_idx = 0, pulses = 0, vld_cnt = 0;
  logic sclk_d = 1'b0;
  always @(negedge clk) begin
    if (sclk_o && !sclk_d) begin
      pulses++;
      if (adc_idx < DW) line = adc_word[DW-1-adc_idx];
      else              line = 1'b1;
      adc_idx++;
    end
    sclk_d = sclk_o;
    if (word_vld_o) vld_cnt++;
  end

  // cycle reference model
  int m_st = 0, m_cnt = 0, m_bits = 0;
  bit m_s1 = 0, m_s2 = 0, m_seen = 0, m_sclk = 0, m_ext = 0, m_vld = 0;
  logic [DW-1:0] m_sh = '0, m_word = '0;
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_bits = 0; m_s1 = 0; m_s2 = 0; m_seen = 0;
      m_sclk = 0; m_ext = 0; m_vld = 0; m_sh = '0; m_word = '0;
    end else begin
      bit os2;
      os2 = m_s2; m_s2 = m_s1; m_s1 = line;
      m_vld = 0;
      if (m_st == 0) begin
        if (m_seen && !os2) begin
          m_st = 1; m_cnt = 0; m_sclk = 0; m_bits = 0; m_ext = mode_ext; m_seen = 0;
        end else if (os2) m_seen = 1;
      end else if (m_st == 3) begin
        m_word = m_sh; m_vld = 1; m_st = 0;
      end else if (m_cnt == HALF - 1) begin
        m_cnt = 0;
        if (!m_sclk) m_sclk = 1;
        else begin
          m_sclk = 0;
          if (m_st == 1) begin
            m_sh = {m_sh[DW-2:0], os2};
            m_bits++;
            if (m_bits == DW) m_st = m_ext ? 2 : 3;
          end else m_st = 3;
        end
      end else m_cnt++;
    end
  end

  always @(negedge clk) if (!rst) begin
    chk(sclk_o == m_sclk, "R5/R2 sclk per cycle", sclk_o, m_sclk);
    chk(word_vld_o == m_vld, "R6 strobe per cycle", word_vld_o, m_vld);
    chk(word_o == m_word, "R6/R4 word per cycle", word_o, m_word);
  end

  task automatic convert(input logic [DW-1:0] w, input bit ext, input bit flip);
    int v0;
    @(negedge clk);
    mode_ext = ext; adc_word = w; adc_idx = 0; line = 1'b1;
    repeat (6) @(negedge clk);
    pulses = 0; v0 = vld_cnt; line = 1'b0;
    if (flip) begin
      repeat (40) @(negedge clk);
      mode_ext = !ext;
    end
    for (int i = 0; i < 2000 && vld_cnt == v0; i++) @(negedge clk);
    chk(word_o == w, "R4 captured word", word_o, w);
    chk(pulses == (ext ? DW + 1 : DW), flip ? "R9 length after mode flip" : "R3 pulse count",
        pulses, ext ? DW + 1 : DW);
    repeat (60) @(negedge clk);
    chk(vld_cnt == v0 + 1, "R7 one strobe per read", vld_cnt, v0 + 1);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    chk(sclk_o == 0 && word_vld_o == 0 && word_o == '0, "R1 reset outputs",
        {sclk_o, word_vld_o, word_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk_o == 0 && word_vld_o == 0 && word_o == '0, "R1 after reset",
        {sclk_o, word_vld_o, word_o}, 0);
    // line low since reset: must not start (R8)
    pulses = 0;
    repeat (50) @(negedge clk);
    chk(pulses == 0 && vld_cnt == 0, "R8 low after reset ignored", pulses, 0);
    convert(24'hA5C3F1, 1'b0, 1'b0);
    convert(24'h123456, 1'b1, 1'b0);
    chk(line == 1'b1, "R3 extra pulse drives line high", line, 1);
    convert(24'hFFFFFF, 1'b1, 1'b0);
    convert(24'h000000, 1'b0, 1'b0);
    // last bit 0 in short mode: line stays low after re-arm (R8)
    convert(24'h8000F0, 1'b0, 1'b0);
    pulses = 0;
    repeat (100) @(negedge clk);
    chk(pulses == 0, "R8 stale low no start", pulses, 0);
    convert(24'h5A5A5A, 1'b0, 1'b1);
    convert(24'hC0FFEE, 1'b1, 1'b1);
    convert(24'h000001, 1'b0, 1'b0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule